// File: doc/BRIEF.md
# Receive frame interrupt event generator

This block follows an incoming radio frame through strobes from the receive datapath and turns its milestones into interrupt status. A detected length header opens a frame and raises a receive-start event. Received bytes are counted from that point; when the count reaches a programmable MAC header length and the address filter reports a pass in that cycle, an address-match event is raised. The end-of-frame strobe raises a receive-end event. A transmit-done strobe from the transmit side feeds the same status mechanism.

Every event sets a bit in a status register whatever the mask says. Software reads the register with a one-cycle read strobe, which clears the bits it returned. A mask register, loaded through a write strobe, selects which status bits may drive the single interrupt request line, and a global enable qualifies that line. In extended mode the receive-end event is kept back unless the address filter and the frame check sequence both passed at the end of the frame. In basic mode it is raised for every frame.

Top module: `rx_irq_gen`

## Requirements
- R1: A pulse on `hdr_ok` sets status bit 0 (receive start) in the following cycle and opens a frame, restarting the byte count at zero.
- R2: Status bit 1 (address match) is set in the cycle after the `byte_stb` that brings the byte count of the open frame to `mhr_len`, provided `addr_pass` is high in that strobe cycle. It fires at most once per frame. A `mhr_len` of zero never fires it.
- R3: With `ext_mode` low, `frame_end` in an open frame sets status bit 2 (receive end) in the next cycle, whatever `addr_pass` and `fcs_ok` show. The frame is then closed.
- R4: With `ext_mode` high, `frame_end` in an open frame sets status bit 2 only if `addr_pass` and `fcs_ok` are both high in that cycle. The frame is closed either way.
- R5: `byte_stb` and `frame_end` arriving while no frame is open (after reset or after a `frame_end`) change no status bit.
- R6: A pulse on `tx_done` sets status bit 3 (transmit end) in the following cycle.
- R7: Status bits latch regardless of the mask. `stat_q` presents the current status. A cycle with `stat_rd` high clears the bits set in that cycle, but an event arriving in the same cycle still leaves its bit set.
- R8: `mask_wr` loads `mask_wdata` into the mask, visible on `mask_q` next cycle. `irq` is high exactly when `gie` is high and some status bit is set together with its mask bit.
- R9: After reset the status, the mask and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects extended mode |
| mhr_len | input | CNT_W | MAC header length in bytes |
| hdr_ok | input | 1 | Valid length header detected (strobe) |
| byte_stb | input | 1 | One received byte (strobe) |
| frame_end | input | 1 | Frame reception finished (strobe) |
| addr_pass | input | 1 | Address filter result (level) |
| fcs_ok | input | 1 | Frame check sequence valid (level) |
| tx_done | input | 1 | Frame transmission finished (strobe) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask value to write |
| gie | input | 1 | Global interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears returned bits |
| stat_q | output | 4 | Status: bit0 rx start, bit1 addr match, bit2 rx end, bit3 tx end |
| mask_q | output | 4 | Current mask |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted byte counter or open-frame flag is invisible until a header length is crossed or a frame ends. It then shows as an address-match bit one cycle early or late, or missing, or as a receive-end bit after a stray end strobe. All of these appear on `stat_q` one cycle after the strobe that should have acted. A wrong status or mask bit reaches `irq` in the same cycle it is held, as soon as `gie` is high, so the bench pairs each event with a mask and enable setting that exposes it.

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [CNT_W-1:0] mhr_len,
  input  logic             hdr_ok,
  input  logic             byte_stb,
  input  logic             frame_end,
  input  logic             addr_pass,
  input  logic             fcs_ok,
  input  logic             tx_done,
  input  logic             mask_wr,
  input  logic [3:0]       mask_wdata,
  input  logic             gie,
  input  logic             stat_rd,
  output logic [3:0]       stat_q,
  output logic [3:0]       mask_q,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       stat, mask, ev;
  logic             byte_in, am_hit, end_in, end_ok;

  assign byte_in = byte_stb && active && !hdr_ok;
  assign am_hit  = byte_in && (mhr_len != '0) &&
                   ({1'b0, cnt} + 1'b1 == {1'b0, mhr_len});
  assign end_in  = frame_end && active && !hdr_ok;
  assign end_ok  = !ext_mode || (addr_pass && fcs_ok);

  assign ev[0] = hdr_ok;
  assign ev[1] = am_hit && addr_pass;
  assign ev[2] = end_in && end_ok;
  assign ev[3] = tx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (hdr_ok) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (end_in) begin
      active <= 1'b0;
    end else if (byte_in && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat_rd ? 4'b0 : stat) | ev;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  assign stat_q = stat;
  assign mask_q = mask;
  assign irq    = gie && |(stat & mask);
endmodule

module rx_irq_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic             hdr_ok,
  input logic             frame_end,
  input logic             addr_pass,
  input logic             fcs_ok,
  input logic             tx_done,
  input logic             mask_wr,
  input logic [3:0]       mask_wdata,
  input logic             gie,
  input logic             stat_rd,
  input logic [3:0]       stat_q,
  input logic [3:0]       mask_q,
  input logic             irq
);
  a_r1_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |=> stat_q[0]);
  a_r6_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> stat_q[3]);
  a_r4_ext_holds_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && frame_end && !fcs_ok && !hdr_ok && (stat_rd || !stat_q[2])) |=> !stat_q[2]);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tx_done) |=> !stat_q[3]);
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(mask_wdata));
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && (stat_q & mask_q) != 4'b0));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (stat_q == 4'b0 && mask_q == 4'b0 && !irq));
endmodule

bind rx_irq_gen rx_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .hdr_ok(hdr_ok),
  .frame_end(frame_end), .addr_pass(addr_pass), .fcs_ok(fcs_ok),
  .tx_done(tx_done), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .gie(gie), .stat_rd(stat_rd), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_rx_irq_gen.sv
module sim_rx_irq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic ext_mode = 0, hdr_ok = 0, byte_stb = 0, frame_end = 0;
  logic addr_pass = 0, fcs_ok = 0, tx_done = 0, mask_wr = 0, gie = 0, stat_rd = 0;
  logic [CNT_W-1:0] mhr_len = 8'd3;
  logic [3:0] mask_wdata = 0, stat_q, mask_q;
  logic irq;
  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .mhr_len(mhr_len),
    .hdr_ok(hdr_ok), .byte_stb(byte_stb), .frame_end(frame_end),
    .addr_pass(addr_pass), .fcs_ok(fcs_ok), .tx_done(tx_done),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .gie(gie),
    .stat_rd(stat_rd), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic hdr();   @(negedge clk) hdr_ok = 1;    @(negedge clk) hdr_ok = 0;    endtask
  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_stb = 1; @(negedge clk) byte_stb = 0;
    end
  endtask
  task automatic fend();  @(negedge clk) frame_end = 1; @(negedge clk) frame_end = 0; endtask
  task automatic clr();   @(negedge clk) stat_rd = 1;   @(negedge clk) stat_rd = 0;   endtask
  task automatic wmask(input logic [3:0] m);
    @(negedge clk) begin mask_wr = 1; mask_wdata = m; end
    @(negedge clk) mask_wr = 0;
  endtask

  task automatic t_reset();
    chk("R9 status", {1'b0, stat_q}, 5'd0);
    chk("R9 mask/irq", {irq, mask_q}, 5'd0);
  endtask

  task automatic t_basic_frame();
    ext_mode = 0; addr_pass = 1; mhr_len = 3; clr();
    hdr();      chk("R1 rx start", {1'b0, stat_q}, 5'b00001);
    clr(); bytes(2); chk("R2 before header end", {1'b0, stat_q}, 5'd0);
    bytes(1);   chk("R2 at header end", {1'b0, stat_q}, 5'b00010);
    clr(); bytes(4); chk("R2 once per frame", {1'b0, stat_q}, 5'd0);
    addr_pass = 0; fend(); chk("R3 basic end", {1'b0, stat_q}, 5'b00100);
    clr();
  endtask

  task automatic t_addr_fail();
    addr_pass = 0; mhr_len = 2; hdr(); clr(); bytes(3);
    chk("R2 filter fail", {1'b0, stat_q}, 5'd0);
    fend(); clr();
    mhr_len = 0; addr_pass = 1; hdr(); clr(); bytes(5);
    chk("R2 zero length", {1'b0, stat_q}, 5'd0);
    fend(); clr();
  endtask

  task automatic t_ext();
    ext_mode = 1; addr_pass = 1; fcs_ok = 0; mhr_len = 9;
    hdr(); clr(); fend(); chk("R4 bad fcs", {1'b0, stat_q}, 5'd0);
    hdr(); clr(); addr_pass = 0; fcs_ok = 1; fend();
    chk("R4 filter fail", {1'b0, stat_q}, 5'd0);
    hdr(); clr(); addr_pass = 1; fend();
    chk("R4 both pass", {1'b0, stat_q}, 5'b00100);
    clr(); ext_mode = 0;
  endtask

  task automatic t_stray();
    mhr_len = 1; addr_pass = 1; clr();
    bytes(2); fend();
    chk("R5 no open frame", {1'b0, stat_q}, 5'd0);
  endtask

  task automatic t_tx_and_read();
    @(negedge clk) tx_done = 1; @(negedge clk) tx_done = 0;
    chk("R6 tx end", {1'b0, stat_q}, 5'b01000);
    @(negedge clk) begin stat_rd = 1; tx_done = 1; end
    @(negedge clk) begin stat_rd = 0; tx_done = 0; end
    chk("R7 event wins over read", {1'b0, stat_q}, 5'b01000);
    clr(); chk("R7 read clears", {1'b0, stat_q}, 5'd0);
  endtask

  task automatic t_mask();
    gie = 1; hdr();
    chk("R7 latch unmasked", {irq, stat_q}, 5'b00001);
    wmask(4'b1010); chk("R8 mask load", {irq, mask_q}, 5'b01010);
    wmask(4'b0001); chk("R8 irq on", {irq, stat_q}, 5'b10001);
    gie = 0; #1 chk("R8 gie off", {irq, stat_q}, 5'b00001);
    gie = 1; clr(); chk("R8 irq drops", {irq, stat_q}, 5'd0);
    fend(); clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic_frame();
    t_addr_fail();
    t_ext();
    t_stray();
    t_tx_and_read();
    t_mask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule